// File: doc/BRIEF.md
# Termination Select Timing Generator

This block drives the termination-select control for the strobe and mask pads of one data slice. The memory controller marks each read burst with a window signal. The block shifts the start and the end of that window by two 4-bit settings, then drives the result onto one pad control line. The start shift delays the line's assertion. A larger end setting releases the line sooner. Both settings move in half-cycle steps.

The block runs on an internal clock at twice the interface rate, so one tick equals half an interface cycle. It keeps a short shift history of the window signal. From that history it decides, tick by tick, whether termination must be on. Windows whose shifted intervals touch or overlap are merged into one assertion. An enable input forces the line to its idle level. A polarity input chooses whether the active level is high or low. New settings are accepted only while the line is idle.

Top module: `tsel_timing_gen`

## Requirements
- R1: After reset, with the window low, `tselOut` equals `polarityIn`, which is the inactive level.
- R2: Let edge S be the first fast-clock edge that samples `windowIn` high. The line becomes active right after edge S + `onSetIn` + 1. The smallest setting, 0, gives one tick of latency.
- R3: Let edge E be the first edge that samples `windowIn` low again. The line stays active through edge E + (15 − `offSetIn`). It returns to idle right after edge E + (15 − `offSetIn`) + 1. After 16 consecutive low samples of the window, the line is idle from the next edge on.
- R4: While `enableIn` is 0, `tselOut` equals `polarityIn` in every cycle, whatever the window does.
- R5: With `polarityIn` = 0 the active level is 1. With `polarityIn` = 1 the active level is 0 and the timing is unchanged.
- R6: If the release point of R3 is at or before the assertion point of R2, the window produces no pulse.
- R7: When the shifted intervals of two windows overlap or touch, the line stays active without a gap from the first assertion to the last release.
- R8: A change to either setting while the line is active does not act until the line has gone idle. A pulse already in progress ends as the old settings dictate.
- R9: Windows whose shifted intervals are separated produce separate pulses, with the line idle in between.
- R10: When the turn-off setting exceeds 15 − `onSetIn` and the window is long enough, the pulse is trimmed. It spans from S + `onSetIn` + 1 to E + (15 − `offSetIn`) + 1, and is shorter than the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the interface rate; one tick is one half-cycle step |
| rstN | input | 1 | Asynchronous active-low reset |
| windowIn | input | 1 | Read-burst window from the controller, sampled each tick |
| enableIn | input | 1 | 1 enables dynamic termination; 0 holds the line idle |
| polarityIn | input | 1 | 0 selects an active-high line, 1 an active-low line |
| onSetIn | input | 4 | Turn-on delay in ticks |
| offSetIn | input | 4 | Turn-off setting; the release comes 15 minus this value ticks after the window ends |
| tselOut | output | 1 | Termination-select control to the pads |

## Verification
The bench builds the block with its default 4-bit settings, which gives a 16-entry window history. At this size both extremes of each setting fit in a run of a few dozen ticks. The cases cover a zero delay, a full 15-tick delay, a pulse that vanishes, a trimmed pulse, and windows that are either merged or kept apart. With this depth, one bench run also covers a settings change in the middle of a pulse, the drain of the history after an idle stretch, and both polarities.

// File: rtl/tsel_pkg.sv
`timescale 1ns/1ps
package tsel_pkg;
  localparam int SET_W = 4;
  localparam int HIST_N = 1 << SET_W;
  localparam logic [SET_W-1:0] SET_MAX = '1;

  typedef struct packed {
    logic             runEn;
    logic             polInv;
    logic [SET_W-1:0] onDly;
    logic [SET_W-1:0] offDly;
  } tselCtl_t;
endpackage

// File: rtl/tsel_ctrl.sv
`timescale 1ns/1ps
module tsel_ctrl
  import tsel_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             enableIn,
  input  logic             polarityIn,
  input  logic [SET_W-1:0] onSetIn,
  input  logic [SET_W-1:0] offSetIn,
  input  logic             pulseQ,
  output tselCtl_t         ctl
);
  logic [SET_W-1:0] onQ;
  logic [SET_W-1:0] offQ;

  // Settings are captured only while no pulse is in flight.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onQ  <= '0;
      offQ <= '0;
    end else if (!pulseQ) begin
      onQ  <= onSetIn;
      offQ <= SET_MAX - offSetIn;
    end
  end

  always_comb begin
    ctl.runEn  = enableIn;
    ctl.polInv = polarityIn;
    ctl.onDly  = onQ;
    ctl.offDly = offQ;
  end
endmodule

// File: rtl/tsel_dpath.sv
`timescale 1ns/1ps
module tsel_dpath
  import tsel_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     windowIn,
  input  tselCtl_t ctl,
  output logic     pulseQ,
  output logic     tselOut
);
  localparam int IDX_W = SET_W + 1;

  logic [HIST_N-1:0] histQ;
  logic [HIST_N-1:0] spanMask;
  logic [HIST_N-1:0] coreMask;
  logic              extendMode;
  logic              hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) histQ <= '0;
    else       histQ <= {histQ[HIST_N-2:0], windowIn};
  end

  // Per-tap selection: span taps stretch a window, core taps trim it.
  for (genvar j = 0; j < HIST_N; j++) begin : g_tap
    localparam logic [IDX_W-1:0] TAP = IDX_W'(j);
    always_comb begin
      spanMask[j] = (TAP >= {1'b0, ctl.onDly})  && (TAP <= {1'b0, ctl.offDly});
      coreMask[j] = (TAP >= {1'b0, ctl.offDly}) && (TAP <= {1'b0, ctl.onDly});
    end
  end

  always_comb begin
    extendMode = (ctl.offDly >= ctl.onDly);
    if (extendMode) hit = |(histQ & spanMask);
    else            hit = &(histQ | ~coreMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pulseQ <= 1'b0;
    else       pulseQ <= hit & ctl.runEn;
  end

  assign tselOut = (pulseQ & ctl.runEn) ^ ctl.polInv;
endmodule

// File: rtl/tsel_timing_gen.sv
`timescale 1ns/1ps
module tsel_timing_gen
  import tsel_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             windowIn,
  input  logic             enableIn,
  input  logic             polarityIn,
  input  logic [SET_W-1:0] onSetIn,
  input  logic [SET_W-1:0] offSetIn,
  output logic             tselOut
);
  tselCtl_t ctl;
  logic     pulseQ;

  tsel_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enableIn   (enableIn),
    .polarityIn (polarityIn),
    .onSetIn    (onSetIn),
    .offSetIn   (offSetIn),
    .pulseQ     (pulseQ),
    .ctl        (ctl)
  );

  tsel_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .windowIn (windowIn),
    .ctl      (ctl),
    .pulseQ   (pulseQ),
    .tselOut  (tselOut)
  );
endmodule

// File: rtl/tsel_timing_chk.sv
`timescale 1ns/1ps
module tsel_timing_chk
  import tsel_pkg::*;
(
  input logic     clk,
  input logic     rstN,
  input logic     windowIn,
  input logic     enableIn,
  input logic     polarityIn,
  input logic     tselOut,
  input logic     pulseQ,
  input tselCtl_t ctl
);
  logic [SET_W:0] idleCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       idleCnt <= '0;
    else if (windowIn)               idleCnt <= '0;
    else if (idleCnt < (SET_W+1)'(HIST_N)) idleCnt <= idleCnt + 1'b1;
  end

  AST_IDLE_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !enableIn |-> (tselOut == polarityIn)); // R4
  AST_ACTIVE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (enableIn && pulseQ) |-> (tselOut == !polarityIn)); // R5
  AST_SETTINGS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    pulseQ |=> ($stable(ctl.onDly) && $stable(ctl.offDly))); // R8
  AST_DRAIN_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (idleCnt >= (SET_W+1)'(HIST_N)) |=> !pulseQ); // R3
endmodule

bind tsel_timing_gen tsel_timing_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .windowIn   (windowIn),
  .enableIn   (enableIn),
  .polarityIn (polarityIn),
  .tselOut    (tselOut),
  .pulseQ     (pulseQ),
  .ctl        (ctl)
);

// File: tb/tsel_timing_gen_tb.sv
`timescale 1ns/1ps
module tsel_timing_gen_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       windowIn = 1'b0;
  logic       enableIn = 1'b1;
  logic       polarityIn = 1'b0;
  logic [3:0] onSetIn = '0;
  logic [3:0] offSetIn = '0;
  logic       tselOut;

  int checkCnt = 0;
  int failCnt = 0;
  bit doneFlag = 1'b0;

  always #2 clk = ~clk;

  tsel_timing_gen u_dut (
    .clk(clk), .rstN(rstN), .windowIn(windowIn), .enableIn(enableIn),
    .polarityIn(polarityIn), .onSetIn(onSetIn), .offSetIn(offSetIn),
    .tselOut(tselOut)
  );

  task automatic check(input string tag, input logic got, input logic expv);
    checkCnt++;
    if (got !== expv) begin
      failCnt++;
      $display("FAIL %s: tselOut=%0b expected=%0b at %0t", tag, got, expv, $time);
    end
  endtask

  function automatic bit inWin(int i, int s, int l);
    return (l > 0) && (i >= s) && (i < s + l);
  endfunction

  // Active interval for one window, from the turn-on and turn-off rules.
  function automatic bit inPulse(int m, int s, int l, int on, int off);
    return (l > 0) && (m >= s + on + 1) && (m < s + l + (15 - off) + 1);
  endfunction

  task automatic settle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // Generic scenario: up to two windows, optional turn-off change at changeAt.
  task automatic runCase(input string tag, input int on, input int offA, input int offB,
                         input int changeAt, input int s1, input int l1,
                         input int s2, input int l2, input int n,
                         input logic pol, input logic en);
    @(negedge clk);
    windowIn = 1'b0; onSetIn = 4'(on); offSetIn = 4'(offA);
    polarityIn = pol; enableIn = en;
    settle(20);
    for (int i = 0; i <= n; i++) begin
      bit act;
      @(negedge clk);
      if (i > 0) begin
        act = inPulse(i-1, s1, l1, on, offA) || inPulse(i-1, s2, l2, on, offB);
        check(tag, tselOut, (act & en) ^ pol);
      end
      if (i == changeAt) offSetIn = 4'(offB);
      windowIn = inWin(i, s1, l1) || inWin(i, s2, l2);
    end
    windowIn = 1'b0;
    settle(20);
  endtask

  task automatic testReset();
    rstN = 1'b0; polarityIn = 1'b0; enableIn = 1'b1; windowIn = 1'b0;
    settle(3);
    check("R1 reset low", tselOut, 1'b0);
    polarityIn = 1'b1;
    #1 check("R1 reset inverted", tselOut, 1'b1);
    polarityIn = 1'b0;
    @(negedge clk); rstN = 1'b1;
    settle(3);
    check("R1 after reset", tselOut, 1'b0);
  endtask

  task automatic testTiming();
    runCase("R2 mid delay",  5, 10, 10, -1, 0, 4, 0, 0, 20, 1'b0, 1'b1);
    runCase("R2 zero delay", 0, 15, 15, -1, 0, 4, 0, 0, 12, 1'b0, 1'b1);
    runCase("R3 max stretch", 15, 0, 0, -1, 0, 3, 0, 0, 24, 1'b0, 1'b1);
    runCase("R3 late release", 2, 4, 4, -1, 0, 5, 0, 0, 24, 1'b0, 1'b1);
  endtask

  task automatic testShapes();
    runCase("R6 vanished", 12, 5, 5, -1, 0, 2, 0, 0, 24, 1'b0, 1'b1);
    runCase("R10 trimmed", 8, 12, 12, -1, 0, 10, 0, 0, 24, 1'b0, 1'b1);
    runCase("R7 merged",   2, 5, 5, -1, 0, 3, 8, 3, 26, 1'b0, 1'b1);
    runCase("R9 separate", 0, 15, 15, -1, 0, 4, 7, 3, 14, 1'b0, 1'b1);
  endtask

  task automatic testLevels();
    runCase("R5 active low", 3, 9, 9, -1, 0, 4, 0, 0, 16, 1'b1, 1'b1);
    runCase("R4 disabled",   3, 9, 9, -1, 0, 4, 0, 0, 16, 1'b0, 1'b0);
    runCase("R4 disabled inv", 3, 9, 9, -1, 0, 4, 0, 0, 16, 1'b1, 1'b0);
    runCase("R4 re-enabled", 3, 9, 9, -1, 0, 4, 0, 0, 16, 1'b0, 1'b1);
  endtask

  task automatic testHold();
    // Turn-off raised mid-pulse; the first pulse must keep its old release.
    runCase("R8 hold", 1, 10, 15, 9, 0, 6, 20, 4, 30, 1'b0, 1'b1);
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  endtask

  initial begin
    testReset();
    testTiming();
    testShapes();
    testLevels();
    testHold();
    finishRun();
  end

  initial begin
    #(4 * 200000);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog: run=hung expected=finished");
    finishRun();
  end
endmodule